// File: doc/BRIEF.md
# Multi-channel timer compare unit

This block watches a free-running 64-bit time count supplied from outside and compares it against a bank of up to sixteen 64-bit compare values. Each channel can be enabled on its own. When an enabled channel's value equals the count, the block emits a one-cycle event on that channel and latches a sticky status flag. Software clears the flag by writing a one to it.

Channel 0 has a second role. When the counter-reset enable is set, a channel 0 match drives a combinational reset request back to the counter. The counter then wraps to zero on the next edge and acts as a cyclic period timer. With a cycle time T and a count increment d, software loads channel 0 with T - d, so the count wraps to zero exactly at T.

Shadow mode double-buffers the compare values. Software writes land in a shadow copy. All shadow copies move into the active compare registers together, on the clock edge where channel 0 resets the counter. New compare values therefore take effect only at a cycle boundary.

Top module: `timer_compare_bank`

## Requirements
- R1: After a synchronous active-low reset the configuration, status and every compare word read 0, `match_o` is all zero and `count_reset_o` is low.
- R2: The register map is word-addressed: address 0 is configuration, address 1 is status, address 2+2n is the low word (bits 31:0) of channel n and 3+2n its high word (bits 63:32). Reads are combinational. Any address outside the map reads 0, and writes to it change nothing.
- R3: Configuration bit 0 enables the counter reset, bit n+1 enables channel n, and bit 17 enables shadow mode. Bits above 17 read 0.
- R4: When enabled channel n's active value equals `count_i` at a clock edge and did not at the previous edge, `match_o[n]` is high for exactly the one cycle after that edge. A count held at the value yields one pulse only.
- R5: Status bit n becomes 1 in the same cycle as a `match_o[n]` pulse. It stays 1 until a status write with bit n set; a written 0 leaves it unchanged. A new event in the clearing cycle keeps the bit set.
- R6: A channel whose enable bit is 0 never pulses `match_o` and never sets its status bit, even when its value equals the count.
- R7: `count_reset_o` is high, combinationally in the same cycle, exactly while config bit 0 and bit 1 are set and channel 0's active value equals `count_i`.
- R8: With an external counter that adds d per cycle and clears on `count_reset_o`, loading channel 0 with T-d gives a count that never reaches T and channel 0 events exactly T/d cycles apart.
- R9: With shadow mode off, a compare word write reaches the active value at the write edge, so the written value can match from the next edge.
- R10: With shadow mode on, compare writes change the read-back value but not the active value. All channels copy shadow to active on the edge at which `count_reset_o` is high.
- R11: In shadow mode, a compare write in the same cycle as a wrap lands in the shadow copy only. The transfer at that edge uses the shadow contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| count_i | input | 64 | Current time count |
| reg_we_i | input | 1 | Register write strobe |
| reg_waddr_i | input | ADDR_W (6) | Register write word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_raddr_i | input | ADDR_W (6) | Register read word address |
| reg_rdata_o | output | 32 | Combinational read data |
| count_reset_o | output | 1 | Request to clear the counter on the next edge |
| match_o | output | NUM_CH (16) | Per-channel one-cycle match events |

## Verification
The count is tried at values that equal a compare value only in the low word, to separate a 32-bit compare from a full 64-bit one. It is also held on a matching value for several cycles, which separates edge-detected events from level events, and driven from a wrapping counter, which checks the reset loop and the cycle period. Shadow behaviour is probed in three ways: the old value, the new value, and a write in the wrap cycle. Together these tell a direct update, a transfer at the wrap, and a transfer that wrongly picks up the same-cycle write apart from one another. A behavioural model of status, events and the reset request is compared with the outputs on every clock.

// File: rtl/tcb_pkg.sv
// Shared constants for the timer compare bank: word widths, the
// configuration bit positions and the register word map.
package tcb_pkg;
    localparam int CMP_WORD_W     = 32;
    localparam int CNT_W          = 64;
    localparam int MAX_CHANNELS   = 16;
    localparam int CFG_RESET_BIT  = 0;
    localparam int CFG_SHADOW_BIT = 17;
    localparam int ADDR_CFG       = 0;
    localparam int ADDR_STATUS    = 1;
    localparam int ADDR_CMP_BASE  = 2;

    // Word address of a channel's low (hi=0) or high (hi=1) compare word.
    function automatic int cmp_addr(input int ch, input int hi);
        return ADDR_CMP_BASE + 2 * ch + hi;
    endfunction
endpackage

// File: rtl/tcb_channel.sv
// One compare channel: shadow and active 64-bit compare values plus the
// equality comparator against the time count.
// Assumes: writes arrive one 32-bit word at a time; xfer_i is only
// honoured while shadow mode is on.
module tcb_channel
    import tcb_pkg::*;
#(
    parameter int CH     = 0,
    parameter int ADDR_W = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CNT_W-1:0]      count_i,
    input  logic                  we_i,
    input  logic [ADDR_W-1:0]     waddr_i,
    input  logic [CMP_WORD_W-1:0] wdata_i,
    input  logic                  shadow_en_i,
    input  logic                  xfer_i,
    output logic                  eq_o,
    output logic [CNT_W-1:0]      shadow_o
);
    logic [CNT_W-1:0] shadow_q;
    logic [CNT_W-1:0] active_q;
    logic             lo_wr;
    logic             hi_wr;

    assign lo_wr = we_i && (waddr_i == ADDR_W'(cmp_addr(CH, 0)));
    assign hi_wr = we_i && (waddr_i == ADDR_W'(cmp_addr(CH, 1)));

    // Shadow copy: always takes software writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
        end else begin
            if (lo_wr) shadow_q[CMP_WORD_W-1:0] <= wdata_i;
            if (hi_wr) shadow_q[CNT_W-1:CMP_WORD_W] <= wdata_i;
        end
    end

    // Active value: direct writes without shadow mode, wrap transfer with it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= '0;
        end else if (!shadow_en_i) begin
            if (lo_wr) active_q[CMP_WORD_W-1:0] <= wdata_i;
            if (hi_wr) active_q[CNT_W-1:CMP_WORD_W] <= wdata_i;
        end else if (xfer_i) begin
            active_q <= shadow_q;
        end
    end

    assign eq_o     = (active_q == count_i);
    assign shadow_o = shadow_q;

    p_direct_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!shadow_en_i && lo_wr) |=> (active_q[CMP_WORD_W-1:0] == $past(wdata_i)));
    p_shadow_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (shadow_en_i && !xfer_i) |=> $stable(active_q));
    p_shadow_xfer_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (shadow_en_i && xfer_i) |=> (active_q == $past(shadow_q)));
endmodule

// File: rtl/tcb_event_ctrl.sv
// Configuration and status registers, event edge detection, counter
// reset request and the read-back multiplexer.
// Assumes: eq_i comes straight from the channel comparators and shadow_i
// holds each channel's software-visible compare value.
module tcb_event_ctrl
    import tcb_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int ADDR_W = 6
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              we_i,
    input  logic [ADDR_W-1:0]                 waddr_i,
    input  logic [CFG_SHADOW_BIT:0]           cfg_wdata_i,
    input  logic [ADDR_W-1:0]                 raddr_i,
    input  logic [NUM_CH-1:0]                 eq_i,
    input  logic [NUM_CH-1:0][CNT_W-1:0]      shadow_i,
    output logic                              shadow_en_o,
    output logic                              count_reset_o,
    output logic [NUM_CH-1:0]                 match_o,
    output logic [CMP_WORD_W-1:0]             rdata_o
);
    logic              rst_en_q;
    logic              shadow_q;
    logic [NUM_CH-1:0] en_q;
    logic [NUM_CH-1:0] status_q;
    logic [NUM_CH-1:0] hit;
    logic [NUM_CH-1:0] hit_q;
    logic [NUM_CH-1:0] clr;
    logic              cfg_wr;
    logic              stat_wr;

    assign cfg_wr  = we_i && (waddr_i == ADDR_W'(ADDR_CFG));
    assign stat_wr = we_i && (waddr_i == ADDR_W'(ADDR_STATUS));
    assign hit     = eq_i & en_q;
    assign clr     = stat_wr ? cfg_wdata_i[NUM_CH-1:0] : '0;

    assign count_reset_o = rst_en_q && hit[0];
    assign shadow_en_o   = shadow_q;

    // Configuration register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_en_q <= 1'b0;
            en_q     <= '0;
            shadow_q <= 1'b0;
        end else if (cfg_wr) begin
            rst_en_q <= cfg_wdata_i[CFG_RESET_BIT];
            en_q     <= cfg_wdata_i[NUM_CH:1];
            shadow_q <= cfg_wdata_i[CFG_SHADOW_BIT];
        end
    end

    // Edge detection, event pulses and sticky status (set beats clear).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q    <= '0;
            match_o  <= '0;
            status_q <= '0;
        end else begin
            hit_q    <= hit;
            match_o  <= hit & ~hit_q;
            status_q <= (status_q & ~clr) | (hit & ~hit_q);
        end
    end

    // Combinational read-back of all mapped words; zero elsewhere.
    always_comb begin
        rdata_o = '0;
        if (raddr_i == ADDR_W'(ADDR_CFG)) begin
            rdata_o[CFG_RESET_BIT]  = rst_en_q;
            rdata_o[NUM_CH:1]       = en_q;
            rdata_o[CFG_SHADOW_BIT] = shadow_q;
        end else if (raddr_i == ADDR_W'(ADDR_STATUS)) begin
            rdata_o[NUM_CH-1:0] = status_q;
        end
        for (int c = 0; c < NUM_CH; c++) begin
            if (raddr_i == ADDR_W'(cmp_addr(c, 0))) rdata_o = shadow_i[c][CMP_WORD_W-1:0];
            if (raddr_i == ADDR_W'(cmp_addr(c, 1))) rdata_o = shadow_i[c][CNT_W-1:CMP_WORD_W];
        end
    end

    p_reset_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (count_reset_o && !hit_q[0]) |=> match_o[0]);

    for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
        p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
            match_o[n] |=> !match_o[n]);
        p_disabled_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !en_q[n] |=> !match_o[n]);
        p_status_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
            match_o[n] |-> status_q[n]);
        p_status_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(status_q[n]) |-> match_o[n]);
    end
endmodule

// File: rtl/timer_compare_bank.sv
// Top of the timer compare bank: a generated row of compare channels
// and the shared event/configuration controller.
// Assumes: NUM_CH is between 1 and 16; the counter outside clears on
// the edge at which count_reset_o is high.
module timer_compare_bank
    import tcb_pkg::*;
#(
    parameter  int NUM_CH = 16,
    localparam int ADDR_W = $clog2(ADDR_CMP_BASE + 2 * NUM_CH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CNT_W-1:0]      count_i,
    input  logic                  reg_we_i,
    input  logic [ADDR_W-1:0]     reg_waddr_i,
    input  logic [CMP_WORD_W-1:0] reg_wdata_i,
    input  logic [ADDR_W-1:0]     reg_raddr_i,
    output logic [CMP_WORD_W-1:0] reg_rdata_o,
    output logic                  count_reset_o,
    output logic [NUM_CH-1:0]     match_o
);
    logic [NUM_CH-1:0]            eq;
    logic [NUM_CH-1:0][CNT_W-1:0] shadow_vals;
    logic                         shadow_en;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        tcb_channel #(.CH(c), .ADDR_W(ADDR_W)) i_ch (
            .clk         (clk),
            .rst_n       (rst_n),
            .count_i     (count_i),
            .we_i        (reg_we_i),
            .waddr_i     (reg_waddr_i),
            .wdata_i     (reg_wdata_i),
            .shadow_en_i (shadow_en),
            .xfer_i      (count_reset_o),
            .eq_o        (eq[c]),
            .shadow_o    (shadow_vals[c])
        );
    end

    tcb_event_ctrl #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) i_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .we_i          (reg_we_i),
        .waddr_i       (reg_waddr_i),
        .cfg_wdata_i   (reg_wdata_i[CFG_SHADOW_BIT:0]),
        .raddr_i       (reg_raddr_i),
        .eq_i          (eq),
        .shadow_i      (shadow_vals),
        .shadow_en_o   (shadow_en),
        .count_reset_o (count_reset_o),
        .match_o       (match_o),
        .rdata_o       (reg_rdata_o)
    );
endmodule

// File: tb/test_timer_compare_bank.sv
module test_timer_compare_bank;
    localparam int NCH = 16;
    localparam int AW  = 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [63:0]     count_i = 64'd0;
    logic            we = 1'b0;
    logic [AW-1:0]   waddr = '0;
    logic [AW-1:0]   raddr = '0;
    logic [31:0]     wdata = '0;
    wire  [31:0]     rdata;
    wire             cnt_rst;
    wire  [NCH-1:0]  match;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int last_p0 = -1;
    int pc[NCH];
    bit chk_on  = 0;
    bit run_cnt = 0;

    // reference model state
    logic [31:0]    m_cfg;
    logic [NCH-1:0] m_stat, m_hitq, m_evt, mh, mclr;
    logic [63:0]    m_sh[NCH];
    logic [63:0]    m_act[NCH];
    logic           mxf;
    bit             lo, hi;

    timer_compare_bank #(.NUM_CH(NCH)) i_timer_compare_bank (
        .clk(clk), .rst_n(rst_n), .count_i(count_i),
        .reg_we_i(we), .reg_waddr_i(waddr), .reg_wdata_i(wdata),
        .reg_raddr_i(raddr), .reg_rdata_o(rdata),
        .count_reset_o(cnt_rst), .match_o(match));

    always #5 clk = ~clk;

    function automatic logic m_hit(int n);
        return m_cfg[n+1] && (m_act[n] == count_i);
    endfunction

    function automatic logic m_rst();
        return m_cfg[0] && m_hit(0);
    endfunction

    // behavioural model, updated on every clock edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cfg = 0; m_stat = 0; m_hitq = 0; m_evt = 0;
            for (int n = 0; n < NCH; n++) begin m_sh[n] = 0; m_act[n] = 0; end
        end else begin
            for (int n = 0; n < NCH; n++) mh[n] = m_hit(n);
            mxf   = m_rst();
            m_evt = mh & ~m_hitq;
            m_hitq = mh;
            mclr = (we && waddr == 1) ? wdata[NCH-1:0] : '0;
            m_stat = (m_stat & ~mclr) | m_evt;
            for (int n = 0; n < NCH; n++) begin
                lo = we && (waddr == AW'(2 + 2*n));
                hi = we && (waddr == AW'(3 + 2*n));
                if (m_cfg[17]) begin
                    if (mxf) m_act[n] = m_sh[n];
                end else begin
                    if (lo) m_act[n][31:0] = wdata;
                    if (hi) m_act[n][63:32] = wdata;
                end
                if (lo) m_sh[n][31:0] = wdata;
                if (hi) m_sh[n][63:32] = wdata;
            end
            if (we && waddr == 0) m_cfg = wdata & 32'h0003_FFFF;
        end
    end

    // per-clock comparison against the model
    always begin
        @(posedge clk); #3;
        cyc++;
        if (chk_on) begin
            checks++;
            if (match !== m_evt) begin
                fails++;
                $display("FAIL R4 match_o actual=%h expected=%h", match, m_evt);
            end
            checks++;
            if (cnt_rst !== m_rst()) begin
                fails++;
                $display("FAIL R7 count_reset_o actual=%b expected=%b", cnt_rst, m_rst());
            end
            for (int n = 0; n < NCH; n++) if (match[n] === 1'b1) pc[n]++;
            if (run_cnt) begin
                checks++;
                if (count_i >= 64'd40) begin
                    fails++;
                    $display("FAIL R8 count actual=%0d expected below 40", count_i);
                end
                if (match[0] === 1'b1) begin
                    if (last_p0 >= 0) begin
                        checks++;
                        if (cyc - last_p0 != 10) begin
                            fails++;
                            $display("FAIL R8 period actual=%0d expected=10", cyc - last_p0);
                        end
                    end
                    last_p0 = cyc;
                end
            end
        end
    end

    // external counter for the cycle-timer test: step 4, clear on request
    always @(negedge clk) if (run_cnt) count_i = cnt_rst ? 64'd0 : count_i + 64'd4;

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk); we = 1'b1; waddr = AW'(a); wdata = d;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic set_cnt(input logic [63:0] v);
        @(negedge clk); count_i = v;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd_chk(input int a, input logic [31:0] exp, input string tag);
        @(negedge clk); raddr = AW'(a); #1;
        checks++;
        if (rdata !== exp) begin
            fails++;
            $display("FAIL %s read addr %0d actual=%h expected=%h", tag, a, rdata, exp);
        end
    endtask

    task automatic clr_pc();
        for (int n = 0; n < NCH; n++) pc[n] = 0;
    endtask

    task automatic pc_chk(input int ch, input int exp, input string tag);
        checks++;
        if (pc[ch] != exp) begin
            fails++;
            $display("FAIL %s pulses ch%0d actual=%0d expected=%0d", tag, ch, pc[ch], exp);
        end
    endtask

    task automatic bit_chk(input logic act, input logic exp, input string tag);
        #1;
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
    end

    initial begin
        clr_pc();
        idle(3);
        rst_n = 1'b1;
        chk_on = 1;
        // R1 reset state
        rd_chk(0, 0, "R1"); rd_chk(1, 0, "R1"); rd_chk(2, 0, "R1"); rd_chk(33, 0, "R1");
        @(negedge clk); bit_chk(cnt_rst, 1'b0, "R1 count_reset_o");
        // R3 config bits, R2 map
        set_cnt(64'hDEAD_BEEF);
        wr(0, 32'hFFFF_FFFF); rd_chk(0, 32'h0003_FFFF, "R3");
        wr(0, 0); rd_chk(0, 0, "R3");
        wr(16, 32'hA5A5_0001); wr(17, 32'h0000_0007);
        rd_chk(16, 32'hA5A5_0001, "R2"); rd_chk(17, 32'h7, "R2");
        wr(40, 32'h1234_5678); rd_chk(40, 0, "R2");
        rd_chk(16, 32'hA5A5_0001, "R2"); rd_chk(0, 0, "R2"); rd_chk(1, 0, "R2");
        // R4 full 64-bit match, one pulse per arrival
        wr(8, 5); wr(9, 1); wr(0, 32'h10);
        clr_pc(); set_cnt(64'h5); idle(3); pc_chk(3, 0, "R4 low word only");
        set_cnt(64'h1_0000_0005); idle(4); pc_chk(3, 1, "R4 held");
        set_cnt(0); set_cnt(64'h1_0000_0005); idle(3); pc_chk(3, 2, "R4 re-arrival");
        // R5 sticky status and write-one-to-clear
        rd_chk(1, 32'h8, "R5 set");
        wr(1, 0); rd_chk(1, 32'h8, "R5 write zero");
        wr(1, 32'h8); rd_chk(1, 0, "R5 clear");
        set_cnt(0);
        @(negedge clk); count_i = 64'h1_0000_0005; we = 1'b1; waddr = AW'(1); wdata = 32'h8;
        @(negedge clk); we = 1'b0;
        rd_chk(1, 32'h8, "R5 set beats clear");
        wr(1, 32'h8);
        // R6 disabled channel
        wr(12, 32'h77); wr(13, 0);
        clr_pc(); set_cnt(64'h77); idle(4); pc_chk(5, 0, "R6");
        rd_chk(1, 0, "R6 status");
        // R7 counter reset request
        wr(2, 100); wr(3, 0); wr(0, 32'h2);
        set_cnt(64'd100); @(negedge clk); bit_chk(cnt_rst, 1'b0, "R7 reset disabled");
        wr(0, 32'h3); bit_chk(cnt_rst, 1'b1, "R7 reset enabled");
        // R8 cycle timer: d=4, T=40, channel 0 = 36
        set_cnt(0); wr(2, 36);
        clr_pc(); last_p0 = -1;
        @(negedge clk); run_cnt = 1;
        idle(60);
        run_cnt = 0;
        checks++;
        if (pc[0] < 5) begin
            fails++;
            $display("FAIL R8 pulses actual=%0d expected at least 5", pc[0]);
        end
        // R9 direct write without shadow mode
        set_cnt(64'd1000);
        wr(0, 32'h8); wr(6, 500); wr(7, 0);
        clr_pc(); set_cnt(64'd500); idle(3); pc_chk(2, 1, "R9");
        // R10 shadow mode
        set_cnt(64'd1000);
        wr(0, 32'h0002_000B);
        wr(6, 600); rd_chk(6, 600, "R10 readback");
        clr_pc(); set_cnt(64'd600); idle(3); pc_chk(2, 0, "R10 not yet active");
        set_cnt(64'd500); idle(3); pc_chk(2, 1, "R10 old value active");
        set_cnt(64'd36); idle(2); pc_chk(0, 1, "R10 wrap");
        set_cnt(64'd600); idle(3); pc_chk(2, 2, "R10 after wrap");
        // R11 write in the wrap cycle
        set_cnt(64'd1000);
        @(negedge clk); count_i = 64'd36; we = 1'b1; waddr = AW'(6); wdata = 700;
        @(negedge clk); we = 1'b0; count_i = 64'd1000;
        clr_pc(); set_cnt(64'd700); idle(3); pc_chk(2, 0, "R11 new value held back");
        set_cnt(64'd600); idle(3); pc_chk(2, 1, "R11 pre-write value moved");
        set_cnt(64'd36); idle(2);
        set_cnt(64'd700); idle(3); pc_chk(2, 2, "R11 next wrap");
        rd_chk(6, 700, "R11 readback");
        idle(2);
        summary();
    end
endmodule